// File: doc/BRIEF.md
# Floating-Point Exception Status Updater

This block runs after every floating-point operation and maintains the 16-bit status word of a stack-based floating-point unit. Each operation reports the exceptions it raised, along with a rounding hint for the C1 condition bit. The block combines these with the mask field of the control word and with a flag that says whether the result goes to memory. From that it builds the next status word, the set of unmasked exceptions that must trap, and a one-cycle interrupt request for an unmasked divide by zero.

Exception handling follows a priority scheme rather than a plain OR. Invalid and zero-divide hide every other exception. An unmasked denormal stops processing early. C1 and the precision flag are cleared by fixed rules for stack faults and for unmasked overflow or underflow toward memory. The block also writes a compare relation into the condition bits and decodes the precision-control and rounding-control fields of the control word. The status word, the trap set and the interrupt request are registered and change together one clock after the operation is presented.

Top module: `fpx_status_update`

## Requirements
- R1: `exc_raised` bits are 0 invalid, 1 denormal, 2 zero-divide, 3 overflow, 4 underflow, 5 precision, 6 stack fault and 7 C1 hint. The unmasked set is `exc_raised[5:0] & ~ctrl_word[5:0]`. `trap_set` shows the result of an accepted operation in the next cycle and is zero after any cycle without `op_valid`.
- R2: When invalid or zero-divide is raised, only those two bits can appear in `trap_set`.
- R3: Status bits are 0 IE, 1 DE, 2 ZE, 3 OE, 4 UE, 5 PE, 6 SF, 7 ES, 8 C0, 9 C1, 10 C2, 13:11 TOP, 14 C3 and 15 B. A non-empty unmasked set (after the R2 filter) sets both ES and B.
- R4: On invalid, every raised bit is ORed into the status word, with the hint going to C1. A stack fault raised without the hint clears C1.
- R5: On zero-divide without invalid, only ZE is added; all other raised bits are ignored. If ZE is unmasked, `irq_req` is high for exactly the cycle in which the status update appears.
- R6: A raised denormal sets DE. If DE is unmasked, `trap_set` is DE alone and no other raised bit enters the status word.
- R7: Otherwise, all raised bits are ORed in. Precision raised without the hint clears C1. Precision never appears in `trap_set`.
- R8: An unmasked overflow or underflow with a register destination (`mem_dest`=0) is dropped from `trap_set`. With a memory destination, it is kept, C1 is cleared, and PE is cleared unless it was set before the operation.
- R9: With `cmp_valid`, `cmp_rel` (00 greater, 01 less, 10 equal, 11 unordered) replaces C0/C2/C3 as none / C0 / C3 / all three. C1 and the other bits stay unchanged. The compare is applied after any same-cycle exception update.
- R10: `prec_sel` decodes `ctrl_word[9:8]`: 00 gives 00 (single), 10 gives 01 (double), 11 gives 10 (extended), and the reserved 01 gives 10. `round_mode` equals `ctrl_word[11:10]`.
- R11: Reset clears the status word, `trap_set` and `irq_req`.
- R12: In a cycle with neither `op_valid` nor `cmp_valid`, the status word holds. Exception bits 6:0 never clear except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation result is presented this cycle |
| exc_raised | input | 8 | Raised exceptions and C1 hint (R1 encoding) |
| ctrl_word | input | 16 | Control word: masks 5:0, precision 9:8, rounding 11:10 |
| mem_dest | input | 1 | Destination of the operation is memory |
| cmp_valid | input | 1 | Apply a compare relation this cycle |
| cmp_rel | input | 2 | Compare relation code (R9) |
| status_word | output | 16 | Registered status word |
| trap_set | output | 6 | Registered unmasked exceptions that must trap |
| irq_req | output | 1 | One-cycle interrupt request for unmasked zero-divide |
| prec_sel | output | 2 | Decoded precision selection |
| round_mode | output | 2 | Rounding mode field |

## Verification
The bound checker watches several rules on every cycle:
- masked bits never reach the trap set, and precision never does;
- invalid and zero-divide exclude all other trap bits;
- a non-empty trap set implies ES and B;
- an interrupt request implies ZE;
- an unordered compare lights all three condition bits;
- exception flags are sticky and the status word is stable when idle.

The C1 clearing rules, the PE restore on memory overflow, the early exit for an unmasked denormal and the precision decode depend on the inputs of the operation. Only the bench scenarios can show these, by comparing against independently computed status words.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   localparam int SW_W    = 16;
   localparam int CW_W    = 16;
   localparam int EXC_W   = 6;
   localparam int RAISE_W = 8;

   localparam int B_IE   = 0;
   localparam int B_DE   = 1;
   localparam int B_ZE   = 2;
   localparam int B_OE   = 3;
   localparam int B_UE   = 4;
   localparam int B_PE   = 5;
   localparam int B_SF   = 6;
   localparam int B_ES   = 7;
   localparam int B_C0   = 8;
   localparam int B_C1   = 9;
   localparam int B_C2   = 10;
   localparam int B_C3   = 14;
   localparam int B_BUSY = 15;
   localparam int R_HINT = 7;

   localparam int CW_PC_LO = 8;
   localparam int CW_RC_LO = 10;

   typedef enum logic [1:0] {
      REL_GT = 2'b00,
      REL_LT = 2'b01,
      REL_EQ = 2'b10,
      REL_UN = 2'b11
   } rel_e;

   typedef enum logic [1:0] {
      PREC_SGL = 2'b00,
      PREC_DBL = 2'b01,
      PREC_EXT = 2'b10
   } prec_e;
endpackage

// File: rtl/fpx_exc_resolve.sv
module fpx_exc_resolve
   import fpx_pkg::*;
#(
   parameter int SWW = SW_W,
   parameter int NEX = EXC_W,
   parameter int NRS = RAISE_W
) (
   input  logic [SWW-1:0] sw_old,
   input  logic [NRS-1:0] raised,
   input  logic [NEX-1:0] mask,
   input  logic           mem_dest,
   output logic [SWW-1:0] sw_new,
   output logic [NEX-1:0] trap,
   output logic           zdiv_req
);
   localparam logic [NEX-1:0] HARD_SET = NEX'((1 << B_IE) | (1 << B_ZE));
   localparam logic [NEX-1:0] DEN_ONLY = NEX'(1 << B_DE);
   localparam logic [NEX-1:0] OU_SET   = NEX'((1 << B_OE) | (1 << B_UE));

   logic [SWW-1:0] rmap;
   logic [NEX-1:0] unm;
   logic           hint;

   always_comb begin
      rmap = '0;
      for (int i = 0; i <= B_SF; i++) rmap[i] = raised[i];
      rmap[B_C1] = raised[R_HINT];
   end

   assign hint = raised[R_HINT];

   always_comb begin
      sw_new   = sw_old;
      trap     = '0;
      zdiv_req = 1'b0;
      unm      = raised[NEX-1:0] & ~mask;
      if (raised[B_IE] || raised[B_ZE]) unm = unm & HARD_SET;
      if (|unm) begin
         sw_new[B_ES]   = 1'b1;
         sw_new[B_BUSY] = 1'b1;
      end
      if (raised[B_IE]) begin
         sw_new = sw_new | rmap;
         if (raised[B_SF] && !hint) sw_new[B_C1] = 1'b0;
         trap = unm;
      end else if (raised[B_ZE]) begin
         sw_new[B_ZE] = 1'b1;
         zdiv_req     = unm[B_ZE];
         trap         = unm;
      end else if (raised[B_DE] && unm[B_DE]) begin
         sw_new[B_DE] = 1'b1;
         trap         = DEN_ONLY;
      end else begin
         sw_new = sw_new | rmap;
         if (raised[B_PE] && !hint) sw_new[B_C1] = 1'b0;
         unm[B_PE] = 1'b0;
         if ((unm & OU_SET) != '0) begin
            if (!mem_dest) begin
               unm = unm & ~OU_SET;
            end else begin
               sw_new[B_C1] = 1'b0;
               if (!sw_old[B_PE]) sw_new[B_PE] = 1'b0;
            end
         end
         trap = unm;
      end
   end
endmodule

// File: rtl/fpx_cond_map.sv
module fpx_cond_map
   import fpx_pkg::*;
#(
   parameter int SWW = SW_W
) (
   input  logic [SWW-1:0] sw_in,
   input  logic           apply,
   input  logic [1:0]     rel,
   output logic [SWW-1:0] sw_out
);
   logic c0, c2, c3;

   always_comb begin
      unique case (rel_e'(rel))
         REL_UN:  {c3, c2, c0} = 3'b111;
         REL_LT:  {c3, c2, c0} = 3'b001;
         REL_EQ:  {c3, c2, c0} = 3'b100;
         default: {c3, c2, c0} = 3'b000;
      endcase
   end

   always_comb begin
      sw_out = sw_in;
      if (apply) begin
         sw_out[B_C0] = c0;
         sw_out[B_C2] = c2;
         sw_out[B_C3] = c3;
      end
   end
endmodule

// File: rtl/fpx_ctrl_decode.sv
module fpx_ctrl_decode
   import fpx_pkg::*;
#(
   parameter int CWW             = CW_W,
   parameter bit RESERVED_AS_EXT = 1'b1
) (
   input  logic [CWW-1:0] cw,
   output logic [1:0]     prec_sel,
   output logic [1:0]     round_mode
);
   logic [1:0] pc;
   assign pc         = cw[CW_PC_LO +: 2];
   assign round_mode = cw[CW_RC_LO +: 2];

   generate
      if (RESERVED_AS_EXT) begin : g_rsv_ext
         always_comb begin
            unique case (pc)
               2'b00:   prec_sel = PREC_SGL;
               2'b10:   prec_sel = PREC_DBL;
               default: prec_sel = PREC_EXT;
            endcase
         end
      end else begin : g_rsv_dbl
         always_comb begin
            unique case (pc)
               2'b00:   prec_sel = PREC_SGL;
               2'b11:   prec_sel = PREC_EXT;
               default: prec_sel = PREC_DBL;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/fpx_status_update.sv
module fpx_status_update
   import fpx_pkg::*;
#(
   parameter bit GEN_IRQ         = 1'b1,
   parameter bit RESERVED_AS_EXT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [RAISE_W-1:0] exc_raised,
   input  logic [CW_W-1:0]   ctrl_word,
   input  logic              mem_dest,
   input  logic              cmp_valid,
   input  logic [1:0]        cmp_rel,
   output logic [SW_W-1:0]   status_word,
   output logic [EXC_W-1:0]  trap_set,
   output logic              irq_req,
   output logic [1:0]        prec_sel,
   output logic [1:0]        round_mode
);
   generate
      if (SW_W != 16 || B_BUSY >= SW_W) begin : g_bad_sw
         $error("status word layout does not fit");
      end
      if (EXC_W > RAISE_W || EXC_W > CW_W) begin : g_bad_exc
         $error("exception width inconsistent");
      end
   endgenerate

   logic [SW_W-1:0]  sw_q, sw_exc, sw_sel, sw_next;
   logic [EXC_W-1:0] trap_c, trap_q;
   logic             zdiv_c, irq_q;

   fpx_exc_resolve #(.SWW(SW_W), .NEX(EXC_W), .NRS(RAISE_W)) u_resolve (
      .sw_old  (sw_q),
      .raised  (exc_raised),
      .mask    (ctrl_word[EXC_W-1:0]),
      .mem_dest(mem_dest),
      .sw_new  (sw_exc),
      .trap    (trap_c),
      .zdiv_req(zdiv_c)
   );

   assign sw_sel = op_valid ? sw_exc : sw_q;

   fpx_cond_map #(.SWW(SW_W)) u_cond (
      .sw_in (sw_sel),
      .apply (cmp_valid),
      .rel   (cmp_rel),
      .sw_out(sw_next)
   );

   fpx_ctrl_decode #(.CWW(CW_W), .RESERVED_AS_EXT(RESERVED_AS_EXT)) u_dec (
      .cw        (ctrl_word),
      .prec_sel  (prec_sel),
      .round_mode(round_mode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q   <= '0;
         trap_q <= '0;
      end else begin
         sw_q   <= sw_next;
         trap_q <= op_valid ? trap_c : '0;
      end
   end

   generate
      if (GEN_IRQ) begin : g_irq
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= op_valid & zdiv_c;
         end
      end else begin : g_no_irq
         assign irq_q = 1'b0;
      end
   endgenerate

   assign status_word = sw_q;
   assign trap_set    = trap_q;
   assign irq_req     = irq_q;
endmodule

// File: rtl/fpx_status_chk.sv
module fpx_status_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        op_valid,
   input logic [15:0] ctrl_word,
   input logic        cmp_valid,
   input logic [1:0]  cmp_rel,
   input logic [15:0] status_word,
   input logic [5:0]  trap_set,
   input logic        irq_req
);
   // R1
   trap_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_valid) |-> ((trap_set & $past(ctrl_word[5:0])) == 6'd0));
   // R1
   trap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(op_valid) |-> (trap_set == 6'd0));
   // R2
   hard_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_set[0] || trap_set[2]) |-> ((trap_set & 6'b111010) == 6'd0));
   // R3
   summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_set != 6'd0) |-> (status_word[7] && status_word[15]));
   // R5
   irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (status_word[2] && trap_set[2] && $past(op_valid)));
   // R7
   no_prec_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_set[5]);
   // R9
   unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmp_valid) && $past(cmp_rel) == 2'b11) |->
         (status_word[8] && status_word[10] && status_word[14]));
   // R12
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(status_word[6:0]) & ~status_word[6:0]) == 7'd0));
   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(op_valid) && !$past(cmp_valid)) |-> $stable(status_word));
endmodule

bind fpx_status_update fpx_status_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .ctrl_word  (ctrl_word),
   .cmp_valid  (cmp_valid),
   .cmp_rel    (cmp_rel),
   .status_word(status_word),
   .trap_set   (trap_set),
   .irq_req    (irq_req)
);

// File: tb/fpx_status_update_tb.sv
module fpx_status_update_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [7:0]  exc_raised = '0;
   logic [15:0] ctrl_word = 16'h003F;
   logic        mem_dest = 1'b0;
   logic        cmp_valid = 1'b0;
   logic [1:0]  cmp_rel = '0;
   logic [15:0] status_word;
   logic [5:0]  trap_set;
   logic        irq_req;
   logic [1:0]  prec_sel;
   logic [1:0]  round_mode;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [15:0] exp_sw;

   typedef struct packed { logic [15:0] sw; logic [5:0] trap; logic irq; } res_t;

   always #5 clk = ~clk;

   fpx_status_update u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .exc_raised(exc_raised),
      .ctrl_word(ctrl_word), .mem_dest(mem_dest), .cmp_valid(cmp_valid),
      .cmp_rel(cmp_rel), .status_word(status_word), .trap_set(trap_set),
      .irq_req(irq_req), .prec_sel(prec_sel), .round_mode(round_mode)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Expected behaviour written from the requirements.
   function automatic res_t model(input logic [15:0] old, input logic op, input logic [7:0] e,
                                  input logic [5:0] m, input logic md,
                                  input logic cv, input logic [1:0] rel);
      res_t r;
      logic [5:0] u;
      logic hint;
      r.sw = old; r.trap = '0; r.irq = 1'b0;
      hint = e[7];
      if (op) begin
         u = e[5:0] & ~m;
         if (e[0] || e[2]) u = u & 6'b000101;               // R2
         if (u != 0) r.sw = r.sw | 16'h8080;                // R3
         if (e[0]) begin                                    // R4
            r.sw = r.sw | {6'd0, hint, 2'd0, e[6:0]};
            if (e[6] && !hint) r.sw[9] = 1'b0;
            r.trap = u;
         end else if (e[2]) begin                           // R5
            r.sw[2] = 1'b1;
            r.irq = u[2];
            r.trap = u;
         end else if (e[1] && u[1]) begin                   // R6
            r.sw[1] = 1'b1;
            r.trap = 6'b000010;
         end else begin                                     // R7, R8
            r.sw = r.sw | {6'd0, hint, 2'd0, e[6:0]};
            if (e[5] && !hint) r.sw[9] = 1'b0;
            u[5] = 1'b0;
            if (u[3] || u[4]) begin
               if (!md) begin u[3] = 1'b0; u[4] = 1'b0; end
               else begin
                  r.sw[9] = 1'b0;
                  if (!old[5]) r.sw[5] = 1'b0;
               end
            end
            r.trap = u;
         end
      end
      if (cv) begin                                         // R9
         r.sw[8]  = (rel == 2'b11) || (rel == 2'b01);
         r.sw[10] = (rel == 2'b11);
         r.sw[14] = (rel == 2'b11) || (rel == 2'b10);
      end
      return r;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      exp_sw = '0;
      check("R11 status", status_word, 16'h0000);
      check("R11 trap", {10'd0, trap_set}, 16'h0000);
      check("R11 irq", {15'd0, irq_req}, 16'h0000);
   endtask

   // Presents one cycle of stimulus; returns at the negedge after the update.
   task automatic step(input logic op, input logic [7:0] e, input logic [15:0] cw,
                       input logic md, input logic cv, input logic [1:0] rel);
      @(negedge clk);
      op_valid = op; exc_raised = e; ctrl_word = cw; mem_dest = md;
      cmp_valid = cv; cmp_rel = rel;
      @(negedge clk);
      op_valid = 1'b0; cmp_valid = 1'b0;
   endtask

   task automatic dir(input string tag, input logic [7:0] e, input logic [15:0] cw,
                      input logic md, input logic [15:0] esw, input logic [5:0] etrap,
                      input logic eirq);
      step(1'b1, e, cw, md, 1'b0, 2'b00);
      check({tag, " status"}, status_word, esw);
      check({tag, " trap"}, {10'd0, trap_set}, {10'd0, etrap});
      check({tag, " irq"}, {15'd0, irq_req}, {15'd0, eirq});
   endtask

   task automatic cmp(input logic [1:0] rel, input logic [15:0] esw);
      step(1'b0, 8'h00, 16'h003F, 1'b0, 1'b1, rel);
      check("R9 compare", status_word, esw);
   endtask

   task automatic dec(input logic [1:0] pc, input logic [1:0] rc, input logic [1:0] ep);
      @(negedge clk);
      ctrl_word = {4'd0, rc, pc, 8'h3F};
      #1;
      check("R10 prec", {14'd0, prec_sel}, {14'd0, ep});
      check("R10 round", {14'd0, round_mode}, {14'd0, rc});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      exp_sw = '0;
      do_reset();

      // R4: precision with hint sets C1, then stack-fault invalid clears it
      dir("R7 hint", 8'hA0, 16'h003F, 1'b0, 16'h0220, 6'h00, 1'b0);
      dir("R4 sf", 8'h41, 16'h003F, 1'b0, 16'h0061, 6'h00, 1'b0);
      // R4: stack fault with hint keeps C1 set
      do_reset();
      dir("R4 sf hint", 8'hC1, 16'h003F, 1'b0, 16'h0241, 6'h00, 1'b0);
      // R5, R2: unmasked zero-divide ignores precision
      do_reset();
      dir("R5 zdiv", 8'h24, 16'h003B, 1'b0, 16'h8084, 6'h04, 1'b1);
      step(1'b0, 8'h00, 16'h003B, 1'b0, 1'b0, 2'b00);
      check("R5 irq pulse", {15'd0, irq_req}, 16'h0000);
      check("R12 idle", status_word, 16'h8084);
      // R2: invalid plus zero-divide both unmasked, no irq
      do_reset();
      dir("R2 ie ze", 8'h05, 16'h0000, 1'b0, 16'h8085, 6'h05, 1'b0);
      // R6: unmasked denormal short-circuits
      do_reset();
      dir("R6 den", 8'h0A, 16'h0000, 1'b0, 16'h8082, 6'h02, 1'b0);
      // R8: overflow to register dropped
      do_reset();
      dir("R8 reg", 8'h28, 16'h0037, 1'b0, 16'h80A8, 6'h00, 1'b0);
      // R8: overflow to memory, PE not previously set
      do_reset();
      dir("R8 mem", 8'h28, 16'h0037, 1'b1, 16'h8088, 6'h08, 1'b0);
      // R8: PE already set is retained
      dir("R7 pe", 8'h20, 16'h003F, 1'b0, 16'h80A8, 6'h00, 1'b0);
      dir("R8 mem keep", 8'h28, 16'h0037, 1'b1, 16'h80A8, 6'h08, 1'b0);
      // R9: compare relations, C1 untouched
      do_reset();
      dir("R7 c1", 8'hA0, 16'h003F, 1'b0, 16'h0220, 6'h00, 1'b0);
      cmp(2'b11, 16'h4720);
      cmp(2'b01, 16'h0320);
      cmp(2'b10, 16'h4220);
      cmp(2'b00, 16'h0220);
      // R10: decode of all precision codes
      dec(2'b00, 2'b01, 2'b00);
      dec(2'b10, 2'b10, 2'b01);
      dec(2'b11, 2'b11, 2'b10);
      dec(2'b01, 2'b00, 2'b10);

      // Random mix, reset every few operations to keep sticky bits sparse.
      do_reset();
      for (int n = 0; n < 3000; n++) begin
         logic [7:0] e;
         logic [15:0] cw;
         logic md, cv, opv;
         logic [1:0] rel;
         res_t r;
         if (n % 7 == 6) do_reset();
         e = 8'h00;
         for (int b = 0; b < 8; b++) if ($urandom_range(3) == 0) e[b] = 1'b1;
         cw  = {4'd0, 4'($urandom_range(15)), 2'd0, 6'($urandom_range(63))};
         md  = 1'($urandom_range(1));
         cv  = ($urandom_range(3) == 0);
         opv = ($urandom_range(7) != 0);
         rel = 2'($urandom_range(3));
         r = model(exp_sw, opv, e, cw[5:0], md, cv, rel);
         step(opv, e, cw, md, cv, rel);
         check("R1/R3/R4/R5/R6/R7/R8/R9/R12 status", status_word, r.sw);
         check("R1/R2/R6/R7/R8 trap", {10'd0, trap_set}, {10'd0, r.trap});
         check("R5 irq", {15'd0, irq_req}, {15'd0, r.irq});
         exp_sw = r.sw;
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule